// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block decides when a UART asks a DMA controller to move data into or out of its FIFOs. It watches the receive and transmit FIFO occupancy counts and compares each one against a programmable watermark. It raises a burst request or a single-character request for each channel. Each request is held until the controller acknowledges it, and the block then decides whether to re-issue it.

The receive channel asks for service once its FIFO holds at least the high watermark. After service it waits for the level to fall below the mark and climb back before it asks again. The transmit channel asks for service whenever its FIFO holds fewer entries than the low watermark. It keeps asking after each service for as long as that stays true. Three conditions change this behaviour:
- An active UART error interrupt masks every request.
- Character mode turns both channels into single-character requesters that ignore the watermarks.
- A receive watermark smaller than the DMA burst length is flagged as a configuration error, and receive burst requests are withheld while it lasts.

Top module: `uart_dma_req_gen`

## Requirements
- R1: With receive DMA enabled, the receive burst request goes high on the clock edge that samples a receive level at or above the clamped receive watermark, provided the channel is armed and nothing blocks it.
- R2: After a receive request is acknowledged, no new receive request is raised until a clock edge has sampled the receive level below the watermark and a later edge samples it at or above the mark again.
- R3: With transmit DMA enabled, the transmit burst request goes high on the clock edge that samples a transmit level strictly below the clamped transmit watermark.
- R4: After a transmit acknowledge, if the transmit level is still below the watermark, the request is low for exactly one cycle and is then raised again without any crossing.
- R5: A raised request stays high until its channel's acknowledge is sampled, and it is low from that clock edge on.
- R6: While the error-interrupt input is high, all four request outputs are low in the same cycle and no new request is raised. A request that was already pending reappears once the error input falls.
- R7: With character mode high, only the single-request outputs are used (burst outputs stay low) and the watermarks are ignored. The receive side triggers on a level of 1 or more, and the transmit side triggers on a level below the FIFO depth. Each acknowledge re-arms the channel at once.
- R8: `cfg_err` is high, in the same cycle, whenever the clamped receive watermark is below `BURST_LEN`. While it is high and character mode is off, the receive burst request is not raised.
- R9: A raw watermark of 0 acts as 1, and a raw watermark above `DEPTH` acts as `DEPTH`.
- R10: Clearing a channel's enable drops its request at the next clock edge and restores it to the armed state. Re-enabling it at a level that meets its condition raises a request at the next edge.
- R11: During reset all outputs are low (with the default watermarks) and both channels come out of reset armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | CW | Receive FIFO occupancy |
| tx_level | input | CW | Transmit FIFO occupancy |
| rx_mark_raw | input | CW | Receive high watermark setting |
| tx_mark_raw | input | CW | Transmit low watermark setting |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| char_mode | input | 1 | Character (no-FIFO) mode |
| err_irq | input | 1 | UART error interrupt active |
| rx_ack | input | 1 | Receive request serviced strobe |
| tx_ack | input | 1 | Transmit request serviced strobe |
| rx_burst_req | output | 1 | Receive burst request |
| rx_single_req | output | 1 | Receive single-character request |
| tx_burst_req | output | 1 | Transmit burst request |
| tx_single_req | output | 1 | Transmit single-character request |
| cfg_err | output | 1 | Receive watermark below burst length |

## Verification
The bench separates the receive re-arm rule from the transmit re-issue rule. It holds the level steady after an acknowledge, so a design that treats both channels alike either re-issues on receive or stalls on transmit. It raises the error input while a request is pending, to catch a design that clears the request instead of masking it, or that leaks it through. It uses watermark settings of 0 and above the depth, which expose a missing clamp as a missing or spurious request. It also toggles the enable after an acknowledge, which exposes a design that keeps the stale disarmed state.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    typedef enum logic {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } chan_kind_e;

    typedef struct packed {
        logic burst;
        logic single;
    } req_pair_t;

    // Limit a watermark setting to the legal range 1..depth.
    function automatic int unsigned clamp_mark(input int unsigned raw,
                                               input int unsigned depth);
        if (raw == 0)
            return 1;
        else if (raw > depth)
            return depth;
        else
            return raw;
    endfunction

endpackage

// File: rtl/mark_clamp.sv
module mark_clamp
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] raw_i,
    output logic [CW-1:0] mark_o
);
    int unsigned clamped;

    always_comb begin
        clamped = clamp_mark(32'(raw_i), DEPTH);
        mark_o  = clamped[CW-1:0];
    end

    always_comb begin
        AST_MARK_RANGE: assert (mark_o != '0 && mark_o <= CW'(DEPTH)) // R9
            else $error("clamped watermark out of range");
    end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import uart_dma_pkg::*;
#(
    parameter chan_kind_e KIND  = CH_RX,
    parameter int         DEPTH = 16,
    parameter int         CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level_i,
    input  logic [CW-1:0] mark_i,
    input  logic          en_i,
    input  logic          char_i,
    input  logic          block_i,
    input  logic          ack_i,
    output req_pair_t     req_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic hit;
    logic req_q;
    logic armed_q;

    // Trigger condition for this channel
    always_comb begin
        if (char_i)
            hit = (KIND == CH_RX) ? (level_i != '0) : (level_i < FULL);
        else
            hit = (KIND == CH_RX) ? (level_i >= mark_i) : (level_i < mark_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= 1'b0;
            armed_q <= 1'b1;
        end else if (!en_i) begin
            req_q   <= 1'b0;
            armed_q <= 1'b1;
        end else if (req_q) begin
            if (ack_i) begin
                req_q   <= 1'b0;
                // transmit and character mode stay armed; receive waits for a crossing
                armed_q <= (KIND == CH_TX) || char_i;
            end
        end else if (hit && armed_q && !block_i) begin
            req_q <= 1'b1;
        end else if (!hit) begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        req_o.burst  = req_q && !block_i && !char_i;
        req_o.single = req_q && !block_i && char_i;
    end

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        req_q && ack_i |=> !req_q) // R5
        else $error("request survived acknowledge");

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        req_q && !ack_i && en_i |=> req_q) // R5
        else $error("request dropped without acknowledge");

    AST_NO_ISSUE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        !req_q && block_i |=> !req_q) // R6
        else $error("request issued while blocked");

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !req_q) // R10
        else $error("request held while disabled");
endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
    import uart_dma_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int BURST_LEN = 4,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_level,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_mark_raw,
    input  logic [CW-1:0] tx_mark_raw,
    input  logic          rx_dma_en,
    input  logic          tx_dma_en,
    input  logic          char_mode,
    input  logic          err_irq,
    input  logic          rx_ack,
    input  logic          tx_ack,
    output logic          rx_burst_req,
    output logic          rx_single_req,
    output logic          tx_burst_req,
    output logic          tx_single_req,
    output logic          cfg_err
);
    localparam int NCH = 2;
    localparam logic [CW-1:0] BURST_W = CW'(BURST_LEN);

    logic [CW-1:0] lvl  [NCH];
    logic [CW-1:0] raw  [NCH];
    logic [CW-1:0] mark [NCH];
    logic          en   [NCH];
    logic          ack  [NCH];
    logic          blk  [NCH];
    req_pair_t     rq   [NCH];

    always_comb begin
        lvl[CH_RX] = rx_level;    lvl[CH_TX] = tx_level;
        raw[CH_RX] = rx_mark_raw; raw[CH_TX] = tx_mark_raw;
        en[CH_RX]  = rx_dma_en;   en[CH_TX]  = tx_dma_en;
        ack[CH_RX] = rx_ack;      ack[CH_TX] = tx_ack;
    end

    assign cfg_err = mark[CH_RX] < BURST_W;

    always_comb begin
        blk[CH_RX] = err_irq || (cfg_err && !char_mode);
        blk[CH_TX] = err_irq;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        mark_clamp #(.DEPTH(DEPTH), .CW(CW)) u_clamp (
            .raw_i  (raw[g]),
            .mark_o (mark[g])
        );

        dma_chan_ctl #(.KIND(chan_kind_e'(g)), .DEPTH(DEPTH), .CW(CW)) u_ctl (
            .clk     (clk),
            .rst     (rst),
            .level_i (lvl[g]),
            .mark_i  (mark[g]),
            .en_i    (en[g]),
            .char_i  (char_mode),
            .block_i (blk[g]),
            .ack_i   (ack[g]),
            .req_o   (rq[g])
        );
    end

    assign rx_burst_req  = rq[CH_RX].burst;
    assign rx_single_req = rq[CH_RX].single;
    assign tx_burst_req  = rq[CH_TX].burst;
    assign tx_single_req = rq[CH_TX].single;

    AST_ERR_SILENCES: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> !(rx_burst_req || rx_single_req || tx_burst_req || tx_single_req)) // R6
        else $error("request visible during error");

    AST_CHAR_SINGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        char_mode |-> !rx_burst_req && !tx_burst_req) // R7
        else $error("burst request in character mode");

    AST_CFG_NO_BURST: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !rx_burst_req) // R8
        else $error("receive burst with illegal watermark");
endmodule

// File: tb/sim_uart_dma_req_gen.sv
module sim_uart_dma_req_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int BURST = 4;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [4:0] RXB = 5'b10000, RXS = 5'b01000,
                           TXB = 5'b00100, TXS = 5'b00010, CFG = 5'b00001;

    typedef struct {
        string      tag;
        logic [4:0] v;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic [CW-1:0] rx_level = '0, tx_level = '0;
    logic [CW-1:0] rx_mark_raw = CW'(8), tx_mark_raw = CW'(4);
    logic rx_dma_en = 0, tx_dma_en = 0, char_mode = 0, err_irq = 0, rx_ack = 0, tx_ack = 0;
    logic rx_burst_req, rx_single_req, tx_burst_req, tx_single_req, cfg_err;

    int total = 0, failed = 0;
    bit finished = 0;
    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_dma_req_gen #(.DEPTH(DEPTH), .BURST_LEN(BURST)) u0 (
        .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
        .rx_mark_raw(rx_mark_raw), .tx_mark_raw(tx_mark_raw),
        .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en), .char_mode(char_mode),
        .err_irq(err_irq), .rx_ack(rx_ack), .tx_ack(tx_ack),
        .rx_burst_req(rx_burst_req), .rx_single_req(rx_single_req),
        .tx_burst_req(tx_burst_req), .tx_single_req(tx_single_req), .cfg_err(cfg_err)
    );

    // Driver: one clock edge, then queue the expected outputs for the monitor
    task automatic chk(input string tag, input logic [4:0] e);
        @(posedge clk);
        #1;
        sb.push_back('{tag, e});
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare at the falling edge
    always @(negedge clk) begin
        logic [4:0] obs;
        obs = {rx_burst_req, rx_single_req, tx_burst_req, tx_single_req, cfg_err};
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            total++;
            if (obs !== it.v) begin
                failed++;
                $display("FAIL %s: outputs {rxb,rxs,txb,txs,cfg} actual %b expected %b",
                         it.tag, obs, it.v);
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        chk("R11", 5'b0);
        chk("R11", 5'b0);
        rst = 0;
        // R1 / R2 / R5 receive
        rx_dma_en = 1; rx_level = 7;  chk("R1", 0);
        rx_level = 8;                 chk("R1", RXB);
        rx_level = 9;                 chk("R5", RXB);
        rx_ack = 1;                   chk("R5", 0);
        rx_ack = 0;                   chk("R2", 0);
        rx_level = 8;                 chk("R2", 0);
        rx_level = 7;                 chk("R2", 0);
        rx_level = 8;                 chk("R2", RXB);
        rx_ack = 1;                   chk("R5", 0);
        rx_ack = 0; rx_level = 0;     chk("R2", 0);
        // R3 / R4 transmit
        tx_dma_en = 1; tx_level = 4;  chk("R3", 0);
        tx_level = 3;                 chk("R3", TXB);
        tx_ack = 1;                   chk("R5", 0);
        tx_ack = 0;                   chk("R4", TXB);
        tx_ack = 1;                   chk("R5", 0);
        tx_ack = 0; tx_level = 5;     chk("R4", 0);
        chk("R4", 0);
        tx_level = 2;                 chk("R3", TXB);
        tx_ack = 1;                   chk("R5", 0);
        tx_ack = 0; tx_level = 10;    chk("R3", 0);
        // R6 error masking
        rx_level = 12; err_irq = 1;   chk("R6", 0);
        chk("R6", 0);
        err_irq = 0;                  chk("R6", RXB);
        err_irq = 1;                  chk("R6", 0);
        err_irq = 0;                  chk("R6", RXB);
        rx_ack = 1;                   chk("R5", 0);
        rx_ack = 0; rx_level = 0;     chk("R6", 0);
        // R8 / R9 watermark configuration
        rx_mark_raw = 2; rx_level = 5;   chk("R8", CFG);
        rx_mark_raw = 20; rx_level = 15; chk("R9", 0);
        rx_level = 16;                   chk("R9", RXB);
        rx_ack = 1;                      chk("R5", 0);
        rx_ack = 0; rx_level = 0;        chk("R9", 0);
        rx_mark_raw = 0; rx_level = 1;   chk("R9", CFG);
        rx_mark_raw = 8; rx_level = 0;   chk("R8", 0);
        tx_mark_raw = 0; tx_level = 0;   chk("R9", TXB);
        tx_ack = 1;                      chk("R5", 0);
        tx_ack = 0; tx_level = 10; tx_mark_raw = 4; chk("R9", 0);
        // R7 character mode
        char_mode = 1; rx_level = 1; tx_level = 16; chk("R7", RXS);
        rx_ack = 1;                   chk("R7", 0);
        rx_ack = 0;                   chk("R7", RXS);
        tx_level = 15;                chk("R7", RXS | TXS);
        rx_ack = 1; tx_ack = 1;       chk("R7", 0);
        rx_ack = 0; tx_ack = 0; rx_level = 0; tx_level = 16; chk("R7", 0);
        // R10 enable clearing
        char_mode = 0; rx_level = 8;  chk("R1", RXB);
        rx_ack = 1;                   chk("R5", 0);
        rx_ack = 0;                   chk("R2", 0);
        rx_dma_en = 0;                chk("R10", 0);
        rx_dma_en = 1;                chk("R10", RXB);
        rx_dma_en = 0;                chk("R10", 0);
        tx_level = 2;                 chk("R3", TXB);
        tx_dma_en = 0;                chk("R10", 0);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule